// File: doc/BRIEF.md
# Timed Multi-Key Combo Detector

This block watches five active-low user inputs (three keys, a power button and an AC-present line) and runs a number of independent combo channels over them. Each channel has its own selection mask, its own hold duration and its own set of actions. A channel arms while at least one of its selected inputs is high. Once every selected input has gone low, it counts timebase ticks while they stay low. When the count reaches the programmed hold, the channel fires once.

A firing sets that channel's sticky status bit and triggers the actions the channel enables. The actions of all channels are merged. They are: a battery-disable level that stays latched until reset, an interrupt built from the sticky status bits, an active-low reset-line pulse whose width can be programmed, and a single-cycle system reset request. The timebase tick is a one-cycle strobe supplied from outside. Register access, clock crossing and pad drivers live around the block, not in it.

Top module: `combo_detect_top`

## Requirements
- R1: After reset, `status_o` is all zero, `bat_off_o`, `irq_o` and `sys_rst_req_o` are 0, and `rst_l_o` is 1.
- R2: Mask bit 0 selects key0 (`keys_i[0]`), bit 1 selects key1, bit 2 selects key2, bit 3 selects the power button and bit 4 selects AC-present. A channel counts only while every selected input is low. An unselected input has no effect.
- R3: A channel enters counting on the clock edge where all its selected inputs are first seen low. It fires on the edge of the hold-th tick after that, counting only cycles with `tick_i` high. A hold of 0 fires on the entry edge.
- R4: A channel whose mask is all zero never fires.
- R5: A channel fires at most once per hold. It re-arms only after one of its selected inputs has been seen high. Counting restarts from zero on the next all-low entry.
- R6: A firing sets the channel's `status_o` bit on the same edge. The bit stays set until a cycle with the matching `status_clr_i` bit high clears it. A firing in the clearing cycle wins.
- R7: Action bit 0 enables battery disable, bit 1 the interrupt, bit 2 the reset-line pulse and bit 3 the system reset request. `irq_o` is high while any set status bit belongs to a channel with action bit 1.
- R8: `bat_off_o` rises on the edge after a firing of any channel with action bit 0, and stays high until reset. The actions of channels that fire together are ORed.
- R9: A firing with action bit 2 drives `rst_l_o` low from that edge for exactly the programmed width in ticks. The width resets to 2000 and is loaded by `width_we_i`. A width of 0 produces no pulse.
- R10: A new reset-line pulse trigger during a running pulse reloads the full width.
- R11: Each firing with action bit 3 raises `sys_rst_req_o` for the single cycle after the firing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle timebase strobe, nominally every 5 us |
| keys_i | input | KEY_W (5) | Synchronized input levels: key0, key1, key2, power button, AC-present |
| sel_mask_i | input | NUM_COMBO x KEY_W | Per-channel input selection mask |
| hold_i | input | NUM_COMBO x HOLD_W | Per-channel hold duration in ticks |
| action_i | input | NUM_COMBO x 4 | Per-channel action enables |
| width_we_i | input | 1 | Load strobe for the reset-pulse width |
| width_wdata_i | input | PULSE_W (16) | New reset-pulse width in ticks |
| status_clr_i | input | NUM_COMBO | Write-one-to-clear for the sticky status |
| status_o | output | NUM_COMBO | Sticky per-channel fired status |
| irq_o | output | 1 | Merged interrupt level |
| bat_off_o | output | 1 | Latched battery-disable request |
| rst_l_o | output | 1 | Active-low reset-line pulse |
| sys_rst_req_o | output | 1 | Single-cycle system reset request |

## Verification
The bench builds the block with its default parameters: four channels, five inputs, 32-bit hold counters, a 16-bit pulse width and the 2000-tick width after reset. It drives `tick_i` high on every cycle, so programmed holds of a few ticks fire within a handful of clocks and the default pulse completes in 2000 cycles. Within that budget the bench can time the untouched reset width exactly, as well as the reload on a restart and the zero-width case. Holding the tick low for a stretch shows that counting follows ticks and not clocks.

// File: rtl/combo_pkg.sv
package combo_pkg;
    // number of watched inputs and their positions in the key vector
    localparam int CMB_KEYS     = 5;
    localparam int KEY_K0       = 0;
    localparam int KEY_K1       = 1;
    localparam int KEY_K2       = 2;
    localparam int KEY_PWR      = 3;
    localparam int KEY_AC       = 4;

    // action vector layout
    localparam int CMB_ACTS     = 4;
    localparam int ACT_BAT      = 0;
    localparam int ACT_IRQ      = 1;
    localparam int ACT_RSTL     = 2;
    localparam int ACT_SYS      = 3;

    typedef enum logic [1:0] {
        CH_WAIT_REL = 2'd0,
        CH_ARMED    = 2'd1,
        CH_COUNT    = 2'd2
    } ch_state_e;
endpackage

// File: rtl/combo_channel.sv
module combo_channel
    import combo_pkg::*;
#(
    parameter int KEY_W  = CMB_KEYS,
    parameter int HOLD_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic [KEY_W-1:0]  keys_i,
    input  logic [KEY_W-1:0]  mask_i,
    input  logic [HOLD_W-1:0] hold_i,
    output logic              fire_o
);
    localparam int EXT_W = HOLD_W + 1;

    typedef struct packed {
        ch_state_e         st;
        logic [HOLD_W-1:0] cnt;
    } ch_reg_t;

    ch_reg_t         ch_d, ch_q;
    logic            all_low;
    logic [EXT_W-1:0] cnt_next;
    logic            fire_d;

    always_comb begin
        all_low  = (|mask_i) && ((keys_i & mask_i) == '0);
        cnt_next = {1'b0, ch_q.cnt} + EXT_W'(1);
        ch_d     = ch_q;
        fire_d   = 1'b0;
        unique case (ch_q.st)
            CH_WAIT_REL: begin
                if (!all_low) ch_d.st = CH_ARMED;
            end
            CH_ARMED: begin
                if (all_low) begin
                    if (hold_i == '0) begin
                        fire_d  = 1'b1;
                        ch_d.st = CH_WAIT_REL;
                    end else begin
                        ch_d.st  = CH_COUNT;
                        ch_d.cnt = '0;
                    end
                end
            end
            CH_COUNT: begin
                if (!all_low) begin
                    ch_d.st = CH_ARMED;
                end else if (tick_i) begin
                    if (cnt_next >= {1'b0, hold_i}) begin
                        fire_d  = 1'b1;
                        ch_d.st = CH_WAIT_REL;
                    end else begin
                        ch_d.cnt = cnt_next[HOLD_W-1:0];
                    end
                end
            end
            default: ch_d.st = CH_WAIT_REL;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ch_q <= '{st: CH_WAIT_REL, cnt: '0};
        end else begin
            ch_q <= ch_d;
        end
    end

    assign fire_o = fire_d;
endmodule

// File: rtl/combo_rst_pulse.sv
module combo_rst_pulse #(
    parameter int PULSE_W       = 16,
    parameter int PULSE_DEFAULT = 2000
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               tick_i,
    input  logic               start_i,
    input  logic               width_we_i,
    input  logic [PULSE_W-1:0] width_wdata_i,
    output logic               rst_l_o
);
    typedef struct packed {
        logic [PULSE_W-1:0] width;
        logic [PULSE_W-1:0] remain;
    } pulse_reg_t;

    pulse_reg_t pl_d, pl_q;

    always_comb begin
        pl_d = pl_q;
        if (width_we_i) pl_d.width = width_wdata_i;
        if (start_i) begin
            pl_d.remain = pl_q.width;
        end else if (tick_i && (pl_q.remain != '0)) begin
            pl_d.remain = pl_q.remain - PULSE_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pl_q <= '{width: PULSE_W'(PULSE_DEFAULT), remain: '0};
        end else begin
            pl_q <= pl_d;
        end
    end

    assign rst_l_o = (pl_q.remain == '0);
endmodule

// File: rtl/combo_detect_top.sv
module combo_detect_top
    import combo_pkg::*;
#(
    parameter int NUM_COMBO     = 4,
    parameter int KEY_W         = CMB_KEYS,
    parameter int HOLD_W        = 32,
    parameter int ACT_W         = CMB_ACTS,
    parameter int PULSE_W       = 16,
    parameter int PULSE_DEFAULT = 2000
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic                              tick_i,
    input  logic [KEY_W-1:0]                  keys_i,
    input  logic [NUM_COMBO-1:0][KEY_W-1:0]   sel_mask_i,
    input  logic [NUM_COMBO-1:0][HOLD_W-1:0]  hold_i,
    input  logic [NUM_COMBO-1:0][ACT_W-1:0]   action_i,
    input  logic                              width_we_i,
    input  logic [PULSE_W-1:0]                width_wdata_i,
    input  logic [NUM_COMBO-1:0]              status_clr_i,
    output logic [NUM_COMBO-1:0]              status_o,
    output logic                              irq_o,
    output logic                              bat_off_o,
    output logic                              rst_l_o,
    output logic                              sys_rst_req_o
);
    typedef struct packed {
        logic [NUM_COMBO-1:0] status;
        logic                 bat;
        logic                 sys;
    } top_reg_t;

    top_reg_t             top_d, top_q;
    logic [NUM_COMBO-1:0] chan_fire;
    logic [NUM_COMBO-1:0] bat_sel, irq_sel, rstl_sel, sys_sel;
    logic                 rst_start;

    for (genvar g = 0; g < NUM_COMBO; g++) begin : g_chan
        combo_channel #(
            .KEY_W  (KEY_W),
            .HOLD_W (HOLD_W)
        ) u_chan (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .tick_i (tick_i),
            .keys_i (keys_i),
            .mask_i (sel_mask_i[g]),
            .hold_i (hold_i[g]),
            .fire_o (chan_fire[g])
        );
        assign bat_sel[g]  = action_i[g][ACT_BAT];
        assign irq_sel[g]  = action_i[g][ACT_IRQ];
        assign rstl_sel[g] = action_i[g][ACT_RSTL];
        assign sys_sel[g]  = action_i[g][ACT_SYS];
    end

    always_comb begin
        top_d        = top_q;
        top_d.status = (top_q.status & ~status_clr_i) | chan_fire;
        top_d.bat    = top_q.bat | (|(chan_fire & bat_sel));
        top_d.sys    = |(chan_fire & sys_sel);
        rst_start    = |(chan_fire & rstl_sel);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    combo_rst_pulse #(
        .PULSE_W       (PULSE_W),
        .PULSE_DEFAULT (PULSE_DEFAULT)
    ) u_pulse (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .tick_i        (tick_i),
        .start_i       (rst_start),
        .width_we_i    (width_we_i),
        .width_wdata_i (width_wdata_i),
        .rst_l_o       (rst_l_o)
    );

    assign status_o      = top_q.status;
    assign irq_o         = |(top_q.status & irq_sel);
    assign bat_off_o     = top_q.bat;
    assign sys_rst_req_o = top_q.sys;
endmodule

// File: rtl/combo_detect_chk.sv
module combo_detect_chk
    import combo_pkg::*;
#(
    parameter int NUM_COMBO = 4,
    parameter int KEY_W     = CMB_KEYS,
    parameter int ACT_W     = CMB_ACTS
) (
    input logic                            clk_i,
    input logic                            rst_ni,
    input logic [NUM_COMBO-1:0][KEY_W-1:0] sel_mask_i,
    input logic [NUM_COMBO-1:0][ACT_W-1:0] action_i,
    input logic [NUM_COMBO-1:0]            status_clr_i,
    input logic [NUM_COMBO-1:0]            status_o,
    input logic                            bat_off_o,
    input logic                            rst_l_o,
    input logic                            sys_rst_req_o,
    input logic [NUM_COMBO-1:0]            fire_i,
    input logic                            rst_start_i
);
    logic [NUM_COMBO-1:0] zero_mask;
    logic [NUM_COMBO-1:0] sys_en;

    always_comb begin
        for (int i = 0; i < NUM_COMBO; i++) begin
            zero_mask[i] = (sel_mask_i[i] == '0);
            sys_en[i]    = action_i[i][ACT_SYS];
        end
    end

    // R4: an empty mask keeps its channel silent
    assert_zero_mask_silent_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((fire_i & zero_mask) == '0));

    // R8: battery disable never drops while out of reset
    assert_bat_latched_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bat_off_o |=> bat_off_o);

    // R6: a firing shows up in the sticky status
    assert_fire_sets_status_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|fire_i) |=> ((status_o & $past(fire_i)) == $past(fire_i)));

    // R6: status bits only fall under a clear request
    assert_status_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((($past(status_o) & ~$past(status_clr_i)) & ~status_o) == '0));

    // R9: the reset line only falls after a pulse trigger
    assert_pulse_needs_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(rst_l_o) |-> $past(rst_start_i));

    // R11: the system request follows a firing of an enabled channel
    assert_sysreq_source_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sys_rst_req_o) |-> $past(|(fire_i & sys_en)));
endmodule

bind combo_detect_top combo_detect_chk #(
    .NUM_COMBO (NUM_COMBO),
    .KEY_W     (KEY_W),
    .ACT_W     (ACT_W)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sel_mask_i    (sel_mask_i),
    .action_i      (action_i),
    .status_clr_i  (status_clr_i),
    .status_o      (status_o),
    .bat_off_o     (bat_off_o),
    .rst_l_o       (rst_l_o),
    .sys_rst_req_o (sys_rst_req_o),
    .fire_i        (chan_fire),
    .rst_start_i   (rst_start)
);

// File: tb/tb_combo_detect_top.sv
`timescale 1ns/1ps
module tb_combo_detect_top;
    localparam int NC = 4;
    localparam int KW = 5;
    localparam int HW = 32;
    localparam int AW = 4;
    localparam int PW = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b1;
    logic [KW-1:0]     keys = 5'b11111;
    logic [NC-1:0][KW-1:0] mask;
    logic [NC-1:0][HW-1:0] hold;
    logic [NC-1:0][AW-1:0] act;
    logic              wwe = 1'b0;
    logic [PW-1:0]     wdata = '0;
    logic [NC-1:0]     clr = '0;
    logic [NC-1:0]     status;
    logic              irq, bat, rst_l, sysreq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    combo_detect_top dut (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .keys_i(keys),
        .sel_mask_i(mask), .hold_i(hold), .action_i(act),
        .width_we_i(wwe), .width_wdata_i(wdata), .status_clr_i(clr),
        .status_o(status), .irq_o(irq), .bat_off_o(bat),
        .rst_l_o(rst_l), .sys_rst_req_o(sysreq)
    );

    typedef struct packed {
        logic [4:0] keys;
        logic [7:0] cyc;
        logic [3:0] st;
        logic       irq;
        logic       bat;
    } vec_t;

    // keys bits: [4] AC, [3] power, [2] key2, [1] key1, [0] key0 (R2)
    localparam vec_t VECS [0:10] = '{
        '{5'b11111, 8'd3,  4'b0000, 1'b0, 1'b0},
        '{5'b11110, 8'd10, 4'b0000, 1'b0, 1'b0},
        '{5'b11100, 8'd5,  4'b0000, 1'b0, 1'b0},
        '{5'b11100, 8'd1,  4'b0001, 1'b1, 1'b0},
        '{5'b11100, 8'd10, 4'b0001, 1'b1, 1'b0},
        '{5'b10111, 8'd3,  4'b0001, 1'b1, 1'b0},
        '{5'b10111, 8'd1,  4'b0011, 1'b1, 1'b0},
        '{5'b01111, 8'd1,  4'b0111, 1'b1, 1'b1},
        '{5'b11111, 8'd5,  4'b0111, 1'b1, 1'b1},
        '{5'b00000, 8'd2,  4'b0111, 1'b1, 1'b1},
        '{5'b11111, 8'd2,  4'b0111, 1'b1, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic set_width(input logic [PW-1:0] v);
        wwe = 1'b1; wdata = v;
        step(1);
        wwe = 1'b0;
    endtask

    task automatic clear_all();
        clr = '1;
        step(1);
        clr = '0;
    endtask

    task automatic edges_until_high(output int n);
        n = 0;
        while (rst_l == 1'b0 && n < 5000) begin
            step(1);
            n++;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int n;
        int sys_cnt;
        // ch0: key0+key1, hold 5, interrupt
        mask[0] = 5'b00011; hold[0] = 32'd5; act[0] = 4'b0010;
        // ch1: power, hold 3, reset-line pulse + system request
        mask[1] = 5'b01000; hold[1] = 32'd3; act[1] = 4'b1100;
        // ch2: AC, hold 0, battery disable
        mask[2] = 5'b10000; hold[2] = 32'd0; act[2] = 4'b0001;
        // ch3: empty mask with every action (R4)
        mask[3] = 5'b00000; hold[3] = 32'd0; act[3] = 4'b1111;

        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 status", status, 0);
        check("R1 irq", irq, 0);
        check("R1 bat", bat, 0);
        check("R1 rst_l", rst_l, 1);
        check("R1 sysreq", sysreq, 0);

        // table walk: R2 R3 R4 R7 R8
        for (int v = 0; v <= 10; v++) begin
            keys = VECS[v].keys;
            step(int'(VECS[v].cyc));
            check("R2/R3/R4 status", status, VECS[v].st);
            check("R7 irq", irq, VECS[v].irq);
            check("R8 bat", bat, VECS[v].bat);
        end

        // R8: only reset drops battery disable
        rst_n = 1'b0; step(2); rst_n = 1'b1; step(2);
        check("R8 bat after reset", bat, 0);
        check("R1 status after reset", status, 0);

        // R9 default width, R11 single request
        keys = 5'b10111;
        sys_cnt = 0;
        for (int i = 0; i < 4; i++) begin
            step(1);
            if (sysreq) sys_cnt++;
        end
        check("R9 low after hold", rst_l, 0);
        n = 0;
        while (rst_l == 1'b0 && n < 5000) begin
            step(1);
            n++;
            if (sysreq) sys_cnt++;
        end
        check("R9 default width", n, 2000);
        check("R11 one request", sys_cnt, 1);

        // R10 restart reloads the width
        set_width(16'd20);
        keys = 5'b11111; step(1);
        keys = 5'b10111; step(4);
        check("R9 programmed pulse start", rst_l, 0);
        keys = 5'b11111; step(1);
        keys = 5'b10111; step(4);
        check("R10 still low at retrigger", rst_l, 0);
        edges_until_high(n);
        check("R10 reload width", n, 20);

        // R5 / R6: clear while held, no refire
        clear_all();
        check("R6 clear", status, 0);
        step(10);
        check("R5 no refire while held", status, 0);

        // R9 zero width: no pulse
        set_width(16'd0);
        keys = 5'b11111; step(1);
        keys = 5'b10111; step(4);
        check("R5 refire after release", status, 4'b0010);
        check("R9 zero width stays high", rst_l, 1);
        step(1);
        check("R9 zero width stays high later", rst_l, 1);

        // R3: counting follows ticks
        clear_all();
        keys = 5'b11111; step(2);
        tick = 1'b0;
        keys = 5'b11100; step(20);
        check("R3 no count without tick", status, 0);
        tick = 1'b1;
        step(4);
        check("R3 one tick short", status, 0);
        step(1);
        check("R3 fires on hold tick", status, 4'b0001);
        check("R8 bat not set by ch0", bat, 0);

        // R7 / R8 merge of simultaneous channels
        keys = 5'b11111; step(2);
        clear_all();
        keys = 5'b00000; step(6);
        check("R8 merged status", status, 4'b0111);
        check("R8 merged bat", bat, 1);
        check("R7 merged irq", irq, 1);

        // R6: firing wins over clear in the same cycle
        keys = 5'b11111; step(1);
        keys = 5'b01111;
        clr = 4'b0100;
        step(1);
        clr = '0;
        check("R6 set wins over clear", status[2], 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule